// File: doc/BRIEF.md
# APB Splitter with Per-Child Address Rebasing

This block sits on one upstream APB4 link and spreads its transfers over several downstream completers. The downstream side has two groups. The first is a single region. The second is a row of identical regions laid out one after another at a fixed pitch. The address map is fixed by parameters, and the decode is purely combinational. A transfer reaches one child in the same cycle that the requester presents it, and that child's response goes straight back upstream.

Every child sees only the part of the address that falls inside its own window. The block subtracts the child's base from the upstream address. For a row member, that base is the row origin plus the member index times the pitch. The block then keeps only as many low bits as the window size needs. A child therefore always decodes offsets from zero, whatever its position in the map. An address that falls outside every window selects no child. It completes at once with an error response.

Top module: `apbdec_top`

## Requirements
- R1: A child's select is high exactly when the upstream select is high and the upstream address lies inside that child's window, for both reads and writes. At most one child select is high at a time, and every child that is not addressed keeps its select low.
- R2: A child's write output is high only while that child is selected for a write. It is low during a read to that child and low whenever the child is not selected.
- R3: The single region's address output is (upstream address minus the single base), truncated to log2(single size) bits. With the default 4 KiB window at 0x0, address 0x0FFF gives 0xFFF.
- R4: Row member i spans [row base + i*pitch, row base + (i+1)*pitch). Its address output is (upstream address minus row base minus i*pitch), truncated to log2(pitch) bits. With the default map (base 0x1000, pitch 0x1000, four members), 0x2ABC goes to member 1 as 0xABC, and 0x4FFF goes to member 3 as 0xFFF.
- R5: The 3-bit protection field, the write data and the byte strobes (data width / 8 bits) reach the selected child unchanged.
- R6: A child's enable is high only while that child is selected and the upstream enable is high. It is low in the setup phase.
- R7: While a child is selected, upstream ready, read data and error equal that child's ready, read data and error. A child holding ready low holds the upstream transfer in its access phase.
- R8: An address inside no window (0x5000 and above in the default map) raises no child select. It completes in its access phase with ready high, error high and read data zero. With no transfer in progress, error is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock (used by the bound checker) |
| presetn | input | 1 | Active-low reset (used by the bound checker) |
| psel | input | 1 | Upstream select |
| penable | input | 1 | Upstream access-phase flag |
| pwrite | input | 1 | Upstream direction, 1 = write |
| paddr | input | ADDR_W | Upstream byte address |
| pprot | input | 3 | Upstream protection attributes |
| pwdata | input | DATA_W | Upstream write data |
| pstrb | input | DATA_W/8 | Upstream byte strobes |
| prdata | output | DATA_W | Read data returned upstream |
| pready | output | 1 | Transfer completion upstream |
| pslverr | output | 1 | Error response upstream |
| sgl_psel | output | 1 | Single region select |
| sgl_penable | output | 1 | Single region enable |
| sgl_pwrite | output | 1 | Single region direction |
| sgl_paddr | output | log2(SGL_SIZE) | Single region rebased address |
| sgl_pprot | output | 3 | Single region protection |
| sgl_pwdata | output | DATA_W | Single region write data |
| sgl_pstrb | output | DATA_W/8 | Single region byte strobes |
| sgl_prdata | input | DATA_W | Single region read data |
| sgl_pready | input | 1 | Single region ready |
| sgl_pslverr | input | 1 | Single region error |
| arr_psel | output | ARR_N | Row member selects, bit i = member i |
| arr_penable | output | ARR_N | Row member enables |
| arr_pwrite | output | ARR_N | Row member directions |
| arr_paddr | output | ARR_N*log2(ARR_STRIDE) | Row member rebased addresses, member i in slice i |
| arr_pprot | output | ARR_N*3 | Row member protection |
| arr_pwdata | output | ARR_N*DATA_W | Row member write data |
| arr_pstrb | output | ARR_N*DATA_W/8 | Row member byte strobes |
| arr_prdata | input | ARR_N*DATA_W | Row member read data |
| arr_pready | input | ARR_N | Row member readies |
| arr_pslverr | input | ARR_N | Row member errors |

## Verification
The assertions assume that the upstream side follows APB sequencing. Enable only rises after a setup cycle with select high. Address, direction and write data hold steady from setup through completion. Each window is a power of two in size and aligned to its own size, so a shift of the address picks out the window index. The bench drives every transfer as a setup cycle followed by an access cycle, changes inputs only on the falling clock edge, and keeps the child ready, error and read data constant within each access phase, apart from the single ready rise that ends a wait state.

// File: rtl/apbdec_pkg.sv
package apbdec_pkg;

   localparam int PROT_W = 3;

   // Number of address bits needed to span a window of the given byte size.
   function automatic int addr_bits(input longint unsigned size);
      return (size <= 1) ? 1 : $clog2(size);
   endfunction

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/apbdec_port.sv
// One downstream child: window match, request fan-out and address rebasing.
module apbdec_port
   import apbdec_pkg::*;
#(
   parameter int                 ADDR_W = 32,
   parameter int                 DATA_W = 32,
   parameter logic [ADDR_W-1:0]  BASE   = '0,
   parameter int unsigned        SIZE   = 4096,
   localparam int                CAW    = addr_bits(SIZE),
   localparam int                STRB_W = DATA_W / 8
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [PROT_W-1:0] pprot,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [STRB_W-1:0] pstrb,
   output logic              c_psel,
   output logic              c_penable,
   output logic              c_pwrite,
   output logic [CAW-1:0]    c_paddr,
   output logic [PROT_W-1:0] c_pprot,
   output logic [DATA_W-1:0] c_pwdata,
   output logic [STRB_W-1:0] c_pstrb
);

   logic [ADDR_W-1:0] offset;
   logic              in_window;
   logic              wr_hit;
   logic              rd_hit;

   always_comb begin
      offset    = paddr - BASE;
      in_window = (paddr >= BASE) && (offset < ADDR_W'(SIZE));
      wr_hit    = psel & in_window & pwrite;
      rd_hit    = psel & in_window & ~pwrite;
   end

   assign c_psel    = wr_hit | rd_hit;
   assign c_pwrite  = wr_hit;
   assign c_penable = c_psel & penable;
   assign c_paddr   = offset[CAW-1:0];
   assign c_pprot   = pprot;
   assign c_pwdata  = pwdata;
   assign c_pstrb   = pstrb;

endmodule

// File: rtl/apbdec_resp_mux.sv
// One-hot return path from the selected child back to the requester.
module apbdec_resp_mux #(
   parameter int NCH    = 5,
   parameter int DATA_W = 32
) (
   input  logic [NCH-1:0]        sel,
   input  logic [NCH*DATA_W-1:0] c_prdata,
   input  logic [NCH-1:0]        c_pready,
   input  logic [NCH-1:0]        c_pslverr,
   output logic                  any_sel,
   output logic [DATA_W-1:0]     m_prdata,
   output logic                  m_pready,
   output logic                  m_pslverr
);

   assign any_sel = |sel;

   if (NCH == 1) begin : g_single
      assign m_prdata  = sel[0] ? c_prdata : '0;
      assign m_pready  = sel[0] & c_pready[0];
      assign m_pslverr = sel[0] & c_pslverr[0];
   end else begin : g_andor
      always_comb begin
         m_prdata  = '0;
         m_pready  = 1'b0;
         m_pslverr = 1'b0;
         for (int i = 0; i < NCH; i++) begin
            m_prdata  = m_prdata  | ({DATA_W{sel[i]}} & c_prdata[i*DATA_W +: DATA_W]);
            m_pready  = m_pready  | (sel[i] & c_pready[i]);
            m_pslverr = m_pslverr | (sel[i] & c_pslverr[i]);
         end
      end
   end

endmodule

// File: rtl/apbdec_top.sv
module apbdec_top
   import apbdec_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter logic [ADDR_W-1:0] SGL_BASE   = 'h0,
   parameter int unsigned       SGL_SIZE   = 4096,
   parameter logic [ADDR_W-1:0] ARR_BASE   = 'h1000,
   parameter int                ARR_N      = 4,
   parameter int unsigned       ARR_STRIDE = 4096,
   localparam int               STRB_W     = DATA_W / 8,
   localparam int               SGL_AW     = addr_bits(SGL_SIZE),
   localparam int               ARR_AW     = addr_bits(ARR_STRIDE),
   localparam int               NCH        = ARR_N + 1
) (
   input  logic                      pclk,
   input  logic                      presetn,
   input  logic                      psel,
   input  logic                      penable,
   input  logic                      pwrite,
   input  logic [ADDR_W-1:0]         paddr,
   input  logic [PROT_W-1:0]         pprot,
   input  logic [DATA_W-1:0]         pwdata,
   input  logic [STRB_W-1:0]         pstrb,
   output logic [DATA_W-1:0]         prdata,
   output logic                      pready,
   output logic                      pslverr,
   output logic                      sgl_psel,
   output logic                      sgl_penable,
   output logic                      sgl_pwrite,
   output logic [SGL_AW-1:0]         sgl_paddr,
   output logic [PROT_W-1:0]         sgl_pprot,
   output logic [DATA_W-1:0]         sgl_pwdata,
   output logic [STRB_W-1:0]         sgl_pstrb,
   input  logic [DATA_W-1:0]         sgl_prdata,
   input  logic                      sgl_pready,
   input  logic                      sgl_pslverr,
   output logic [ARR_N-1:0]          arr_psel,
   output logic [ARR_N-1:0]          arr_penable,
   output logic [ARR_N-1:0]          arr_pwrite,
   output logic [ARR_N*ARR_AW-1:0]   arr_paddr,
   output logic [ARR_N*PROT_W-1:0]   arr_pprot,
   output logic [ARR_N*DATA_W-1:0]   arr_pwdata,
   output logic [ARR_N*STRB_W-1:0]   arr_pstrb,
   input  logic [ARR_N*DATA_W-1:0]   arr_prdata,
   input  logic [ARR_N-1:0]          arr_pready,
   input  logic [ARR_N-1:0]          arr_pslverr
);

   localparam longint unsigned SGL_END = longint'(SGL_BASE) + longint'(SGL_SIZE);
   localparam longint unsigned ARR_END = longint'(ARR_BASE) + longint'(ARR_N) * longint'(ARR_STRIDE);

   // ---------------- elaboration-time parameter checks ----------------
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("apbdec_top: DATA_W must be a whole number of bytes");
   end
   if (ARR_N < 1) begin : g_bad_arr_n
      $error("apbdec_top: ARR_N must be at least 1");
   end
   if (!is_pow2(SGL_SIZE) || !is_pow2(ARR_STRIDE)) begin : g_bad_size
      $error("apbdec_top: window sizes must be powers of two");
   end
   if ((longint'(SGL_BASE) % longint'(SGL_SIZE) != 0) ||
       (longint'(ARR_BASE) % longint'(ARR_STRIDE) != 0)) begin : g_bad_align
      $error("apbdec_top: window bases must be aligned to their size");
   end
   if (!((SGL_END <= longint'(ARR_BASE)) || (longint'(SGL_BASE) >= ARR_END))) begin : g_overlap
      $error("apbdec_top: single region overlaps the row");
   end
   if ((SGL_END > (64'd1 << ADDR_W)) || (ARR_END > (64'd1 << ADDR_W))) begin : g_bad_range
      $error("apbdec_top: a window extends past the address space");
   end

   // ---------------- single region ----------------
   apbdec_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BASE   (SGL_BASE),
      .SIZE   (SGL_SIZE)
   ) sgl_port_i (
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pprot     (pprot),
      .pwdata    (pwdata),
      .pstrb     (pstrb),
      .c_psel    (sgl_psel),
      .c_penable (sgl_penable),
      .c_pwrite  (sgl_pwrite),
      .c_paddr   (sgl_paddr),
      .c_pprot   (sgl_pprot),
      .c_pwdata  (sgl_pwdata),
      .c_pstrb   (sgl_pstrb)
   );

   // ---------------- row of identical regions ----------------
   for (genvar gi = 0; gi < ARR_N; gi++) begin : g_row
      localparam logic [ADDR_W-1:0] MEMBER_BASE =
         ARR_BASE + ADDR_W'(gi) * ADDR_W'(ARR_STRIDE);

      apbdec_port #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .BASE   (MEMBER_BASE),
         .SIZE   (ARR_STRIDE)
      ) row_port_i (
         .psel      (psel),
         .penable   (penable),
         .pwrite    (pwrite),
         .paddr     (paddr),
         .pprot     (pprot),
         .pwdata    (pwdata),
         .pstrb     (pstrb),
         .c_psel    (arr_psel[gi]),
         .c_penable (arr_penable[gi]),
         .c_pwrite  (arr_pwrite[gi]),
         .c_paddr   (arr_paddr[gi*ARR_AW +: ARR_AW]),
         .c_pprot   (arr_pprot[gi*PROT_W +: PROT_W]),
         .c_pwdata  (arr_pwdata[gi*DATA_W +: DATA_W]),
         .c_pstrb   (arr_pstrb[gi*STRB_W +: STRB_W])
      );
   end

   // ---------------- response path ----------------
   logic              any_sel;
   logic [DATA_W-1:0] mux_prdata;
   logic              mux_pready;
   logic              mux_pslverr;

   apbdec_resp_mux #(
      .NCH    (NCH),
      .DATA_W (DATA_W)
   ) resp_mux_i (
      .sel       ({arr_psel, sgl_psel}),
      .c_prdata  ({arr_prdata, sgl_prdata}),
      .c_pready  ({arr_pready, sgl_pready}),
      .c_pslverr ({arr_pslverr, sgl_pslverr}),
      .any_sel   (any_sel),
      .m_prdata  (mux_prdata),
      .m_pready  (mux_pready),
      .m_pslverr (mux_pslverr)
   );

   // A miss completes at once and reports an error in its access phase.
   assign prdata  = mux_prdata;
   assign pready  = any_sel ? mux_pready  : 1'b1;
   assign pslverr = any_sel ? mux_pslverr : (psel & penable);

endmodule

// File: rtl/apbdec_chk.sv
module apbdec_chk
   import apbdec_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] SGL_BASE   = 'h0,
   parameter int unsigned       SGL_SIZE   = 4096,
   parameter logic [ADDR_W-1:0] ARR_BASE   = 'h1000,
   parameter int                ARR_N      = 4,
   parameter int unsigned       ARR_STRIDE = 4096
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic              pready,
   input logic              pslverr,
   input logic              sgl_psel,
   input logic              sgl_penable,
   input logic              sgl_pwrite,
   input logic              sgl_pready,
   input logic              sgl_pslverr,
   input logic [ARR_N-1:0]  arr_psel,
   input logic [ARR_N-1:0]  arr_penable,
   input logic [ARR_N-1:0]  arr_pwrite,
   input logic [ARR_N-1:0]  arr_pready,
   input logic [ARR_N-1:0]  arr_pslverr
);

   localparam int SGL_SH = addr_bits(SGL_SIZE);
   localparam int ARR_SH = addr_bits(ARR_STRIDE);

   logic [ARR_N:0]    all_sel;
   logic [ARR_N:0]    all_wr;
   logic [ARR_N:0]    all_en;
   logic [ADDR_W-1:0] row_rel;

   assign all_sel = {arr_psel, sgl_psel};
   assign all_wr  = {arr_pwrite, sgl_pwrite};
   assign all_en  = {arr_penable, sgl_penable};
   assign row_rel = paddr - ARR_BASE;

   assert_one_child_R1: assert property (@(posedge pclk) disable iff (!presetn)
      $onehot0(all_sel));

   assert_sel_needs_req_R1: assert property (@(posedge pclk) disable iff (!presetn)
      (|all_sel) |-> psel);

   assert_wr_only_on_write_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (|all_wr) |-> (psel && pwrite));

   assert_wr_within_sel_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (all_wr & ~all_sel) == '0);

   assert_single_hit_R3: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && ((paddr >> SGL_SH) == (SGL_BASE >> SGL_SH))) |-> sgl_psel);

   for (genvar k = 0; k < ARR_N; k++) begin : g_row_chk
      assert_row_hit_R4: assert property (@(posedge pclk) disable iff (!presetn)
         (psel && (paddr >= ARR_BASE) && ((row_rel >> ARR_SH) == ADDR_W'(k))) |-> arr_psel[k]);

      assert_row_resp_R7: assert property (@(posedge pclk) disable iff (!presetn)
         (arr_psel[k] && penable) |-> ((pready == arr_pready[k]) && (pslverr == arr_pslverr[k])));
   end

   assert_enable_gated_R6: assert property (@(posedge pclk) disable iff (!presetn)
      ((all_en & ~all_sel) == '0) && ((|all_en) -> penable));

   assert_single_resp_R7: assert property (@(posedge pclk) disable iff (!presetn)
      (sgl_psel && penable) |-> ((pready == sgl_pready) && (pslverr == sgl_pslverr)));

   assert_miss_error_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && (all_sel == '0)) |-> (pready && pslverr));

   assert_idle_no_error_R8: assert property (@(posedge pclk) disable iff (!presetn)
      !psel |-> !pslverr);

endmodule

bind apbdec_top apbdec_chk #(
   .ADDR_W     (ADDR_W),
   .SGL_BASE   (SGL_BASE),
   .SGL_SIZE   (SGL_SIZE),
   .ARR_BASE   (ARR_BASE),
   .ARR_N      (ARR_N),
   .ARR_STRIDE (ARR_STRIDE)
) chk_i (.*);

// File: tb/apbdec_top_tb_top.sv
`timescale 1ns/100ps
module apbdec_top_tb_top;

   localparam int NCH = 5;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [31:0] paddr = '0, pwdata = '0;
   logic [2:0]  pprot = '0;
   logic [3:0]  pstrb = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;

   logic        sgl_psel, sgl_penable, sgl_pwrite;
   logic [11:0] sgl_paddr;
   logic [2:0]  sgl_pprot;
   logic [31:0] sgl_pwdata;
   logic [3:0]  sgl_pstrb;
   logic [3:0]  arr_psel, arr_penable, arr_pwrite;
   logic [47:0] arr_paddr;
   logic [11:0] arr_pprot;
   logic [127:0] arr_pwdata;
   logic [15:0] arr_pstrb;
   logic [127:0] arr_prdata;

   logic [NCH-1:0] rdy_v = '1;
   logic [NCH-1:0] err_v = '0;

   int checks = 0;
   int failures = 0;

   always #2.5 pclk = ~pclk;

   // Child models: child k returns 0xA500_0000 | k.
   for (genvar k = 0; k < 4; k++) begin : g_rd
      assign arr_prdata[k*32 +: 32] = 32'hA500_0000 | 32'(k + 1);
   end

   apbdec_top dut_i (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pprot(pprot), .pwdata(pwdata),
      .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .sgl_psel(sgl_psel), .sgl_penable(sgl_penable), .sgl_pwrite(sgl_pwrite),
      .sgl_paddr(sgl_paddr), .sgl_pprot(sgl_pprot), .sgl_pwdata(sgl_pwdata),
      .sgl_pstrb(sgl_pstrb), .sgl_prdata(32'hA500_0000), .sgl_pready(rdy_v[0]),
      .sgl_pslverr(err_v[0]),
      .arr_psel(arr_psel), .arr_penable(arr_penable), .arr_pwrite(arr_pwrite),
      .arr_paddr(arr_paddr), .arr_pprot(arr_pprot), .arr_pwdata(arr_pwdata),
      .arr_pstrb(arr_pstrb), .arr_prdata(arr_prdata), .arr_pready(rdy_v[4:1]),
      .arr_pslverr(err_v[4:1])
   );

   // Uniform child view, index 0 = single region, 1..4 = row members 0..3.
   logic [NCH-1:0] ch_psel, ch_pen, ch_pwr;
   logic [11:0]    ch_paddr [NCH];
   logic [31:0]    ch_pwdata [NCH];
   logic [3:0]     ch_pstrb [NCH];
   logic [2:0]     ch_pprot [NCH];
   assign ch_psel = {arr_psel, sgl_psel};
   assign ch_pen  = {arr_penable, sgl_penable};
   assign ch_pwr  = {arr_pwrite, sgl_pwrite};
   assign ch_paddr[0]  = sgl_paddr;
   assign ch_pwdata[0] = sgl_pwdata;
   assign ch_pstrb[0]  = sgl_pstrb;
   assign ch_pprot[0]  = sgl_pprot;
   for (genvar k = 0; k < 4; k++) begin : g_view
      assign ch_paddr[k+1]  = arr_paddr[k*12 +: 12];
      assign ch_pwdata[k+1] = arr_pwdata[k*32 +: 32];
      assign ch_pstrb[k+1]  = arr_pstrb[k*4 +: 4];
      assign ch_pprot[k+1]  = arr_pprot[k*3 +: 3];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected child for an address in the default map; -1 = unmapped.
   function automatic int exp_child(input logic [31:0] a);
      if (a < 32'h1000) return 0;
      if (a < 32'h5000) return int'(a >> 12);
      return -1;
   endfunction

   task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                       input logic [3:0] strb, input logic [2:0] prot,
                       input int waits, input logic cerr);
      int    k;
      string areq;
      k    = exp_child(addr);
      areq = (k > 0) ? "R4 addr" : "R3 addr";
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr;
      pwdata = data; pstrb = strb; pprot = prot;
      rdy_v = (waits == 0) ? '1 : '0;
      err_v = cerr ? '1 : '0;
      #1;
      for (int j = 0; j < NCH; j++) begin
         chk("R1 sel", 32'(ch_psel[j]), 32'(j == k));
         chk("R2 write", 32'(ch_pwr[j]), 32'(j == k && wr));
         chk("R6 setup enable", 32'(ch_pen[j]), 32'h0);
      end
      if (k >= 0) begin
         chk(areq, 32'(ch_paddr[k]), {20'h0, addr[11:0]});
         chk("R5 wdata", ch_pwdata[k], data);
         chk("R5 strb", 32'(ch_pstrb[k]), 32'(strb));
         chk("R5 prot", 32'(ch_pprot[k]), 32'(prot));
      end
      @(negedge pclk);
      penable = 1'b1;
      for (int w = 0; w < waits; w++) begin
         #1;
         chk("R7 wait ready", 32'(pready), 32'h0);
         @(negedge pclk);
      end
      rdy_v = '1;
      #1;
      for (int j = 0; j < NCH; j++)
         chk("R6 access enable", 32'(ch_pen[j]), 32'(j == k));
      if (k >= 0) begin
         chk("R7 ready", 32'(pready), 32'h1);
         chk("R7 error", 32'(pslverr), 32'(cerr));
         if (!wr) chk("R7 rdata", prdata, 32'hA500_0000 | 32'(k));
      end else begin
         chk("R8 miss ready", 32'(pready), 32'h1);
         chk("R8 miss error", 32'(pslverr), 32'h1);
         chk("R8 miss rdata", prdata, 32'h0);
         chk("R8 miss no sel", 32'(ch_psel), 32'h0);
      end
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic t_reset_state();
      #1;
      chk("R1 reset sel", 32'(ch_psel), 32'h0);
      chk("R6 reset enable", 32'(ch_pen), 32'h0);
      chk("R8 idle error", 32'(pslverr), 32'h0);
   endtask

   task automatic t_single();
      xfer(1'b1, 32'h0000_0124, 32'hDEAD_BEEF, 4'hF, 3'b010, 0, 1'b0);
      xfer(1'b0, 32'h0000_0124, 32'h0, 4'h0, 3'b001, 0, 1'b0);
   endtask

   task automatic t_row_each();
      for (int i = 0; i < 4; i++) begin
         xfer(1'b1, 32'h1000 + 32'(i) * 32'h1000 + 32'h0ABC, 32'h1234_0000 | 32'(i), 4'h5, 3'(i), 0, 1'b0);
         xfer(1'b0, 32'h1000 + 32'(i) * 32'h1000 + 32'h0010, 32'h0, 4'h0, 3'b100, 0, 1'b0);
      end
   endtask

   task automatic t_boundaries();
      xfer(1'b0, 32'h0000_0FFF, 32'h0, 4'h0, 3'b000, 0, 1'b0);
      xfer(1'b0, 32'h0000_1000, 32'h0, 4'h0, 3'b000, 0, 1'b0);
      xfer(1'b1, 32'h0000_2ABC, 32'hCAFE_0001, 4'h3, 3'b111, 0, 1'b0);
      xfer(1'b0, 32'h0000_4FFF, 32'h0, 4'h0, 3'b000, 0, 1'b0);
   endtask

   task automatic t_wait_and_error();
      xfer(1'b0, 32'h0000_3040, 32'h0, 4'h0, 3'b000, 2, 1'b0);
      xfer(1'b1, 32'h0000_0200, 32'h0BAD_0BAD, 4'h8, 3'b000, 1, 1'b1);
      xfer(1'b0, 32'h0000_4008, 32'h0, 4'h0, 3'b000, 0, 1'b1);
   endtask

   task automatic t_unmapped();
      xfer(1'b0, 32'h0000_5000, 32'h0, 4'h0, 3'b000, 0, 1'b0);
      xfer(1'b1, 32'hFFFF_FFF0, 32'h5555_AAAA, 4'hF, 3'b011, 0, 1'b0);
      #1;
      chk("R8 idle after miss", 32'(pslverr), 32'h0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge pclk);
      failures++;
      $display("FAIL R0 watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge pclk);
      t_reset_state();
      @(negedge pclk);
      presetn = 1'b1;
      t_single();
      t_row_each();
      t_boundaries();
      t_wait_and_error();
      t_unmapped();
      repeat (2) @(negedge pclk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule